// File: doc/BRIEF.md
# Deterministic Latency Calculator

This unit turns the raw delay measurements that a PHY reports into transmit and receive datapath latencies in nanoseconds, ready for correcting timestamps. Each delay measurement is an unsigned fixed-point count of sampling-clock cycles, with 8 fraction bits. The receive side also carries a status byte. Its low seven bits hold a bitslip count, and its top bit is an alignment flag worth 33 unit intervals. Both reduce the receive latency.

The sampling clock period is 6.5 ns, and one unit interval (UI) is 1/10.3125 ns. A start pulse captures all inputs. A one-adder shift-and-add datapath runs per direction and takes a fixed number of cycles. The two results then appear together with a single-cycle done pulse. An enable can add a fixed PMA delay in UI. A mode input selects the simulation value or the hardware value of the transmit PMA delay.

Results are signed two's-complement nanoseconds with 16 fraction bits. Internally the sum is formed with 24 fraction bits. The UI constant is 1626882, which is the UI period times 2^24, rounded. The sum is floored to 16 fraction bits with an arithmetic right shift by 8.

Top module: `dl_latency_calc`

## Requirements
- R1: With pma_en=0, tx_lat_ns equals tx_dl*1664, which is the exact value of tx_dl/256 cycles times 6.5 ns in 16-fraction-bit nanoseconds.
- R2: rx_lat_ns equals floor((rx_dl*425984 + u*1626882)/256), where u = P - (slip_stat[6:0] + 33*slip_stat[7]) and P is the receive PMA UI term. The result may be negative and is then given in two's complement.
- R3: With slip_stat=0 and pma_en=0, rx_lat_ns equals rx_dl*1664 exactly.
- R4: With pma_en=1, the PMA term is added inside the 24-fraction-bit sum, before the floor. The transmit term is 80 UI when pma_sim=1 and 79 UI when pma_sim=0. The receive term P is 88 UI in both modes. With pma_en=0 both terms are zero.
- R5: done is high for exactly one cycle. It first goes high after the 29th rising edge that follows the edge sampling start. Both results change in that done cycle and hold their values in every other cycle.
- R6: busy is high from the edge after an accepted start until done rises, and busy is never high together with done. A start while busy is ignored: the result and the done timing follow the first start.
- R7: Inputs are captured on the edge that accepts start. Later changes to tx_dl, rx_dl, slip_stat, pma_en or pma_sim do not affect that result.
- R8: Asserting rst_n low clears busy, done and both results at once, even in the middle of a computation. After rst_n is released, the unit accepts start from the third rising edge onward.
- R9: The extreme inputs are computed without overflow: rx_dl = 2^21-1 with slip_stat=0xFF (u=-160), and rx_dl=0 with slip_stat=0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start strobe; captures all inputs when idle |
| tx_dl | input | 21 | Transmit delay, unsigned cycles with 8 fraction bits |
| rx_dl | input | 21 | Receive delay, unsigned cycles with 8 fraction bits |
| slip_stat | input | 8 | [6:0] bitslip count in UI, [7] alignment flag worth 33 UI |
| pma_en | input | 1 | Add the fixed PMA delay term |
| pma_sim | input | 1 | 1 selects simulation PMA values, 0 selects hardware values |
| tx_lat_ns | output | 36 | Transmit latency, signed ns with 16 fraction bits |
| rx_lat_ns | output | 36 | Receive latency, signed ns with 16 fraction bits |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse marking new results |

## Verification
The bench checks that a zero bitslip with the flag clear gives the plain product exactly. A design that let rounding or a UI term leak in would be off by a few LSBs there. It drives a full bitslip count with the alignment flag, on both a maximal and a zero delay. This exposes a flag weighted wrongly, a lost sign, or truncation toward zero instead of floor on negative results. It also compares the simulation and hardware PMA values to catch a swapped selector. A second start mid-computation, and inputs that change after start, would corrupt the result or shift the done pulse in a design that re-latches its inputs.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  // Fraction bits of the internal accumulator.
  localparam int ACC_FRAC = 24;
  // Sampling clock period in half nanoseconds (6.5 ns).
  localparam int SCLK_HALF_NS = 13;
  // Unit interval in ns scaled by 2^24, rounded (1/10.3125 ns).
  localparam longint UI_Q24 = 64'd1626882;
  // UI weight of the alignment flag.
  localparam int ALIGN_UI = 33;
  // Fixed PMA delays in UI.
  localparam int PMA_TX_SIM = 80;
  localparam int PMA_TX_HW  = 79;
  localparam int PMA_RX     = 88;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dlc_state_e;
endpackage

// File: rtl/dlc_rst_sync.sv
module dlc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
  import dlc_pkg::*;
#(
  parameter int DL_W  = 21,
  parameter int STEPS = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic phase_ui,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(STEPS + 1);

  dlc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    last    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == CNT_W'(STEPS - 1)) begin
          last    = 1'b1;
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign step     = (state_q == ST_RUN);
  assign phase_ui = (cnt_q >= CNT_W'(DL_W));
  assign busy     = (state_q == ST_RUN);
  assign done     = done_q;
endmodule

// File: rtl/dlc_lane.sv
module dlc_lane #(
  parameter int     DL_W   = 21,
  parameter int     MAG_W  = 8,
  parameter int     ACC_W  = 44,
  parameter int     SHIFT  = 8,
  parameter longint SCLK_Q = 425984,
  parameter longint UI_Q   = 1626882
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          step,
  input  logic                          phase_ui,
  input  logic [DL_W-1:0]               dl,
  input  logic [MAG_W-1:0]              ui_mag,
  input  logic                          ui_neg,
  output logic signed [ACC_W-SHIFT-1:0] res_nxt
);
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic        [ACC_W-1:0] mc_q, mc_d;
  logic        [ACC_W-1:0] umc_q, umc_d;
  logic        [DL_W-1:0]  mp_q, mp_d;
  logic        [MAG_W-1:0] ump_q, ump_d;
  logic                    neg_q, neg_d;

  always_comb begin
    acc_d = acc_q;
    mc_d  = mc_q;
    umc_d = umc_q;
    mp_d  = mp_q;
    ump_d = ump_q;
    neg_d = neg_q;
    if (load) begin
      acc_d = '0;
      mc_d  = ACC_W'(SCLK_Q);
      umc_d = ACC_W'(UI_Q);
      mp_d  = dl;
      ump_d = ui_mag;
      neg_d = ui_neg;
    end else if (step) begin
      if (!phase_ui) begin
        if (mp_q[0]) acc_d = acc_q + $signed(mc_q);
        mc_d = mc_q << 1;
        mp_d = mp_q >> 1;
      end else begin
        if (ump_q[0]) begin
          if (neg_q) acc_d = acc_q - $signed(umc_q);
          else       acc_d = acc_q + $signed(umc_q);
        end
        umc_d = umc_q << 1;
        ump_d = ump_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      umc_q <= '0;
      mp_q  <= '0;
      ump_q <= '0;
      neg_q <= 1'b0;
    end else if (load || step) begin
      acc_q <= acc_d;
      mc_q  <= mc_d;
      umc_q <= umc_d;
      mp_q  <= mp_d;
      ump_q <= ump_d;
      neg_q <= neg_d;
    end
  end

  assign res_nxt = acc_d[ACC_W-1:SHIFT];
endmodule

// File: rtl/dl_latency_calc.sv
module dl_latency_calc
  import dlc_pkg::*;
#(
  parameter int DL_W     = 21,
  parameter int DL_FRAC  = 8,
  parameter int SLIP_W   = 7,
  parameter int MAG_W    = 8,
  parameter int ACC_W    = 44,
  parameter int OUT_FRAC = 16,
  localparam int SHIFT   = ACC_FRAC - OUT_FRAC,
  localparam int OUT_W   = ACC_W - SHIFT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DL_W-1:0]         tx_dl,
  input  logic [DL_W-1:0]         rx_dl,
  input  logic [SLIP_W:0]         slip_stat,
  input  logic                    pma_en,
  input  logic                    pma_sim,
  output logic signed [OUT_W-1:0] tx_lat_ns,
  output logic signed [OUT_W-1:0] rx_lat_ns,
  output logic                    busy,
  output logic                    done
);
  localparam int     STEPS  = DL_W + MAG_W;
  localparam int     LANES  = 2;
  localparam longint SCLK_Q = longint'(SCLK_HALF_NS) << (ACC_FRAC - DL_FRAC - 1);

  logic rst_sync_n;
  logic load, step, phase_ui, last;

  dlc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dlc_ctrl #(.DL_W(DL_W), .STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .load     (load),
    .step     (step),
    .phase_ui (phase_ui),
    .last     (last),
    .busy     (busy),
    .done     (done)
  );

  // UI terms: transmit is never negative, receive may be.
  logic [MAG_W-1:0] tx_ui, rx_pma, rx_slip, rx_mag;
  logic             rx_neg;

  always_comb begin
    if (!pma_en)      tx_ui = '0;
    else if (pma_sim) tx_ui = MAG_W'(PMA_TX_SIM);
    else              tx_ui = MAG_W'(PMA_TX_HW);
    rx_pma  = pma_en ? MAG_W'(PMA_RX) : '0;
    rx_slip = MAG_W'(slip_stat[SLIP_W-1:0])
            + (slip_stat[SLIP_W] ? MAG_W'(ALIGN_UI) : '0);
    rx_neg  = (rx_slip > rx_pma);
    rx_mag  = rx_neg ? (rx_slip - rx_pma) : (rx_pma - rx_slip);
  end

  logic [DL_W-1:0]         lane_dl  [LANES];
  logic [MAG_W-1:0]        lane_mag [LANES];
  logic                    lane_neg [LANES];
  logic signed [OUT_W-1:0] lane_res [LANES];

  assign lane_dl[0]  = tx_dl;
  assign lane_mag[0] = tx_ui;
  assign lane_neg[0] = 1'b0;
  assign lane_dl[1]  = rx_dl;
  assign lane_mag[1] = rx_mag;
  assign lane_neg[1] = rx_neg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dlc_lane #(
      .DL_W   (DL_W),
      .MAG_W  (MAG_W),
      .ACC_W  (ACC_W),
      .SHIFT  (SHIFT),
      .SCLK_Q (SCLK_Q),
      .UI_Q   (UI_Q24)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (load),
      .step     (step),
      .phase_ui (phase_ui),
      .dl       (lane_dl[g]),
      .ui_mag   (lane_mag[g]),
      .ui_neg   (lane_neg[g]),
      .res_nxt  (lane_res[g])
    );
  end

  logic signed [OUT_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (last) begin
      tx_q <= lane_res[0];
      rx_q <= lane_res[1];
    end
  end

  assign tx_lat_ns = tx_q;
  assign rx_lat_ns = rx_q;
endmodule

// File: rtl/dlc_chk.sv
module dlc_chk #(
  parameter int STEPS = 29,
  parameter int OUT_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] tx_lat,
  input logic [OUT_W-1:0] rx_lat
);
  localparam int CW = $clog2(STEPS + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done && tx_lat == '0 && rx_lat == '0));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CW'(STEPS)));

  assert_hold_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(tx_lat));

  assert_hold_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_lat));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

bind dl_latency_calc dlc_chk #(.STEPS(STEPS), .OUT_W(OUT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .tx_lat (tx_lat_ns),
  .rx_lat (rx_lat_ns)
);

// File: tb/dl_latency_calc_tb.sv
`timescale 1ns/1ps
module dl_latency_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [20:0] tx_dl, rx_dl;
  logic [7:0]  slip_stat;
  logic        pma_en, pma_sim;
  logic signed [35:0] tx_lat_ns, rx_lat_ns;
  logic        busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dl_latency_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_dl(tx_dl), .rx_dl(rx_dl),
    .slip_stat(slip_stat), .pma_en(pma_en), .pma_sim(pma_sim),
    .tx_lat_ns(tx_lat_ns), .rx_lat_ns(rx_lat_ns), .busy(busy), .done(done)
  );

  function automatic longint model(longint dl, longint ui);
    longint q;
    q = dl * 64'sd425984 + ui * 64'sd1626882;
    return q >>> 8;
  endfunction

  function automatic longint tx_ui(bit en, bit sim);
    return en ? (sim ? 64'sd80 : 64'sd79) : 64'sd0;
  endfunction

  function automatic longint rx_ui(bit en, logic [7:0] s);
    return (en ? 64'sd88 : 64'sd0) - longint'(s[6:0]) - (s[7] ? 64'sd33 : 64'sd0);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(logic [20:0] t, logic [20:0] r, logic [7:0] s, bit en, bit sim);
    @(negedge clk);
    tx_dl = t; rx_dl = r; slip_stat = s; pma_en = en; pma_sim = sim;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 200) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_check(string req, logic [20:0] t, logic [20:0] r,
                           logic [7:0] s, bit en, bit sim);
    int k;
    launch(t, r, s, en, sim);
    wait_done(k);
    check(req, "tx latency", longint'(tx_lat_ns), model(longint'(t), tx_ui(en, sim)));
    check(req, "rx latency", longint'(rx_lat_ns), model(longint'(r), rx_ui(en, s)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    tx_dl = '0; rx_dl = '0; slip_stat = '0; pma_en = 1'b0; pma_sim = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8", "busy after reset", longint'(busy), 0);
    check("R8", "done after reset", longint'(done), 0);
    check("R8", "tx after reset", longint'(tx_lat_ns), 0);
    check("R8", "rx after reset", longint'(rx_lat_ns), 0);
  endtask

  task automatic t_reset_midrun();
    run_check("R8", 21'h0100, 21'h0200, 8'h00, 1'b0, 1'b0);
    launch(21'h1234, 21'h0567, 8'h03, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", "busy cleared mid-run", longint'(busy), 0);
    check("R8", "tx cleared mid-run", longint'(tx_lat_ns), 0);
    check("R8", "rx cleared mid-run", longint'(rx_lat_ns), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_tx_basic();
    run_check("R1", 21'h0027F4, 21'h000100, 8'h00, 1'b0, 1'b0);
    check("R1", "tx exact product", longint'(tx_lat_ns), 64'sd10228 * 64'sd1664);
    run_check("R1", 21'h000001, 21'h000000, 8'h00, 1'b0, 1'b0);
    run_check("R1", 21'h15A5A5, 21'h0A5A5A, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_rx_zero_slip();
    run_check("R3", 21'h000000, 21'h003F80, 8'h00, 1'b0, 1'b0);
    check("R3", "rx exact product", longint'(rx_lat_ns), 64'sd16256 * 64'sd1664);
    run_check("R3", 21'h1FFFFF, 21'h1FFFFF, 8'h00, 1'b0, 1'b0);
    check("R3", "rx max exact", longint'(rx_lat_ns), 64'sd2097151 * 64'sd1664);
  endtask

  task automatic t_rx_slip();
    run_check("R2", 21'h002C00, 21'h002C00, 8'h05, 1'b0, 1'b0);
    run_check("R2", 21'h000000, 21'h002C00, 8'h80, 1'b0, 1'b0);
    run_check("R2", 21'h000000, 21'h0001A3, 8'h41, 1'b0, 1'b0);
    run_check("R2", 21'h000000, 21'h000000, 8'h01, 1'b0, 1'b0);
  endtask

  task automatic t_extreme();
    run_check("R9", 21'h1FFFFF, 21'h1FFFFF, 8'hFF, 1'b0, 1'b0);
    run_check("R9", 21'h000000, 21'h000000, 8'hFF, 1'b0, 1'b0);
    check("R9", "rx negative sign", longint'(rx_lat_ns < 0), 1);
    run_check("R9", 21'h1FFFFF, 21'h000000, 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_pma();
    run_check("R4", 21'h000400, 21'h000400, 8'h00, 1'b1, 1'b1);
    run_check("R4", 21'h000400, 21'h000400, 8'h00, 1'b1, 1'b0);
    run_check("R4", 21'h0027F4, 21'h001111, 8'hA2, 1'b1, 1'b0);
    run_check("R4", 21'h000000, 21'h000000, 8'h58, 1'b1, 1'b1);
    check("R4", "rx pma cancels 88 UI", longint'(rx_lat_ns), 0);
  endtask

  task automatic t_timing();
    int k;
    longint tx0;
    launch(21'h000777, 21'h000333, 8'h02, 1'b0, 1'b0);
    wait_done(k);
    check("R5", "done latency", longint'(k), 29);
    tx0 = longint'(tx_lat_ns);
    @(negedge clk);
    check("R5", "done width", longint'(done), 0);
    repeat (4) @(negedge clk);
    check("R5", "tx hold after done", longint'(tx_lat_ns), tx0);
  endtask

  task automatic t_busy_ignore();
    int k;
    launch(21'h000500, 21'h000600, 8'h07, 1'b0, 1'b0);
    check("R6", "busy after start", longint'(busy), 1);
    repeat (9) @(negedge clk);
    tx_dl = 21'h1F0000; rx_dl = 21'h0F0000; slip_stat = 8'h8F;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(k);
    check("R6", "latency with ignored start", longint'(k + 10), 29);
    check("R6", "busy in done cycle", longint'(busy), 0);
    check("R6", "tx from first start", longint'(tx_lat_ns), model(64'sd1280, 0));
    check("R6", "rx from first start", longint'(rx_lat_ns), model(64'sd1536, -64'sd7));
    @(negedge clk);
    check("R6", "no second done", longint'(done), 0);
  endtask

  task automatic t_latch();
    int k;
    launch(21'h000A00, 21'h000B00, 8'h10, 1'b1, 1'b1);
    tx_dl = 21'h1ABCDE; rx_dl = 21'h012345; slip_stat = 8'hFF; pma_en = 1'b0; pma_sim = 1'b0;
    wait_done(k);
    check("R7", "tx uses captured inputs", longint'(tx_lat_ns), model(64'sd2560, 64'sd80));
    check("R7", "rx uses captured inputs", longint'(rx_lat_ns), model(64'sd2816, 64'sd72));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_tx_basic();
    t_rx_zero_slip();
    t_rx_slip();
    t_extreme();
    t_pma();
    t_timing();
    t_busy_ignore();
    t_latch();
    t_reset_midrun();
    t_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule